// File: doc/BRIEF.md
# Fan PWM Drive Controller

This block drives a fan through a single pulse-width-modulated pin. A small register port holds a configuration byte, a manual fan setting, a forced temperature and a frequency divisor. In manual mode the duty comes straight from the setting written by software. In table mode the duty comes from an external lookup table, and the block supplies that table's index. The index is either the measured temperature or the forced override value.

The PWM period is 64 base ticks. A base tick is one of two fixed rates derived from the system clock, or the fast rate divided by a programmable value. The output can be inverted. New duty values and new tick sources are taken only at a period boundary, so a change never cuts a pulse short. A separate output always carries the measured temperature, for limit comparison elsewhere.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset the configuration reads 0x20, the fan setting reads 0x00, and the PWM pin is low.
- R2: Register addresses are 0 = configuration, 1 = fan setting, 2 = forced temperature, 3 = divisor. Configuration bit 7 always reads 0. Bits 1:0 are stored and read back, and have no effect on the output.
- R3: When configuration bit 5 is 1 (manual), writes to the fan setting take effect. The duty follows the setting, and the lookup input has no effect.
- R4: When bit 5 is 0 (table mode), writes to the fan setting are dropped. The duty follows the lookup input.
- R5: The index output equals the forced temperature when bit 5 is 0 and bit 6 is 1. Otherwise it equals the measured temperature.
- R6: The limit output always equals the measured temperature, whatever bits 5 and 6 hold.
- R7: One period is 64 base ticks. The pin is high for D ticks, where D is bits 7:2 of the duty byte. D = 0 holds the pin low and D = 63 holds it high.
- R8: Configuration bit 4 set inverts the pin, so a duty byte of 0x00 gives a continuously high pin.
- R9: With bit 2 clear, bit 3 = 0 gives a base tick every FAST_DIV clocks and bit 3 = 1 gives one every SLOW_DIV clocks. With bit 2 set, bit 3 is ignored and a tick comes every FAST_DIV*max(divisor,1) clocks.
- R10: The duty and the tick source change only at a period boundary, so every high and low run lasts a whole number of base ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| meas_temp | input | 8 | Measured diode temperature |
| lut_duty | input | 8 | Duty byte returned by the lookup table |
| lut_index | output | 8 | Temperature that indexes the lookup table |
| limit_temp | output | 8 | Temperature for limit checking |
| pwm_out | output | 1 | Fan PWM pin |

## Verification
Register writes are visible on reg_rdata one clock after the write strobe, and the index and limit outputs are combinational, so the bench samples them half a clock after the inputs change. A new duty is taken at the next period boundary and reaches the pin one clock after that. The bench therefore waits two full periods of both the old and the new tick spacing before it counts high cycles over exactly one period. That count does not depend on phase. The boundary rule is checked separately by timing each run of the pin against the tick spacing while writes land at random clock offsets.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam logic [1:0] ADDR_CFG   = 2'd0;
  localparam logic [1:0] ADDR_SET   = 2'd1;
  localparam logic [1:0] ADDR_FORCE = 2'd2;
  localparam logic [1:0] ADDR_DIV   = 2'd3;

  localparam int CFG_FORCE = 6;
  localparam int CFG_PROG  = 5;
  localparam int CFG_INV   = 4;
  localparam int CFG_SLOW  = 3;
  localparam int CFG_OVR   = 2;

  localparam logic [7:0] CFG_RESET = 8'h20;
  localparam logic [7:0] CFG_MASK  = 8'h7F;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_SLOW = 2'd1,
    SRC_DIV  = 2'd2
  } tick_src_e;
endpackage

// File: rtl/fan_cfg_regs.sv
module fan_cfg_regs
  import fan_pwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] set_q,
  output logic [DW-1:0] force_q,
  output logic [DW-1:0] div_q
);
  logic [DW-1:0] cfg_d, set_d, force_d, div_d;

  always_comb begin
    cfg_d   = cfg_q;
    set_d   = set_q;
    force_d = force_q;
    div_d   = div_q;
    if (reg_wr) begin
      case (reg_addr)
        ADDR_CFG:   cfg_d = reg_wdata & DW'(CFG_MASK);
        ADDR_SET:   if (cfg_q[CFG_PROG]) set_d = reg_wdata;
        ADDR_FORCE: force_d = reg_wdata;
        default:    div_d = reg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= DW'(CFG_RESET);
      set_q   <= '0;
      force_q <= '0;
      div_q   <= '0;
    end else begin
      cfg_q   <= cfg_d;
      set_q   <= set_d;
      force_q <= force_d;
      div_q   <= div_d;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CFG:   reg_rdata = cfg_q;
      ADDR_SET:   reg_rdata = set_q;
      ADDR_FORCE: reg_rdata = force_q;
      default:    reg_rdata = div_q;
    endcase
  end
endmodule

// File: rtl/fan_tick_gen.sv
module fan_tick_gen
  import fan_pwm_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 12,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tick_src_e     src,
  input  logic [DW-1:0] div_val,
  output logic          tick
);
  localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [FW-1:0] FAST_LAST = FW'(FAST_DIV - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [FW-1:0] fast_q, fast_d;
  logic [SW-1:0] slow_q, slow_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [DW-1:0] div_last;
  logic          fast_tick, slow_tick, div_tick;

  assign fast_tick = (fast_q == FAST_LAST);
  assign slow_tick = (slow_q == SLOW_LAST);
  assign div_last  = (div_val == '0) ? '0 : div_val - 1'b1;
  assign div_tick  = fast_tick && (dcnt_q >= div_last);

  always_comb begin
    fast_d = fast_tick ? '0 : fast_q + 1'b1;
    slow_d = slow_tick ? '0 : slow_q + 1'b1;
    dcnt_d = dcnt_q;
    if (fast_tick) dcnt_d = div_tick ? '0 : dcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= '0;
      slow_q <= '0;
      dcnt_q <= '0;
    end else begin
      fast_q <= fast_d;
      slow_q <= slow_d;
      dcnt_q <= dcnt_d;
    end
  end

  always_comb begin
    case (src)
      SRC_SLOW: tick = slow_tick;
      SRC_DIV:  tick = div_tick;
      default:  tick = fast_tick;
    endcase
  end
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core
  import fan_pwm_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] duty_in,
  input  logic          invert,
  input  tick_src_e     src_req,
  output tick_src_e     src_q,
  output logic [CW-1:0] duty_q,
  output logic [CW-1:0] cnt_q,
  output logic          pwm_out
);
  logic          boundary;
  logic [CW-1:0] cnt_d, duty_d;
  tick_src_e     src_d;
  logic          raw, pwm_d;

  assign boundary = tick && (cnt_q == '1);

  always_comb begin
    cnt_d  = tick ? cnt_q + 1'b1 : cnt_q;
    duty_d = boundary ? duty_in : duty_q;
    src_d  = boundary ? src_req : src_q;
    raw    = (duty_q == '1) || (cnt_q < duty_q);
    pwm_d  = raw ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      duty_q  <= '0;
      src_q   <= SRC_FAST;
      pwm_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      duty_q  <= duty_d;
      src_q   <= src_d;
      pwm_out <= pwm_d;
    end
  end
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 12,
  parameter int DW       = 8,
  parameter int CW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] meas_temp,
  input  logic [DW-1:0] lut_duty,
  output logic [DW-1:0] lut_index,
  output logic [DW-1:0] limit_temp,
  output logic          pwm_out
);
  logic [DW-1:0] cfg_q, set_q, force_q, div_q;
  logic [CW-1:0] duty_sel, duty_q, cnt_q;
  logic          base_tick;
  tick_src_e     src_req, src_q;

  fan_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_q(cfg_q),
    .set_q(set_q), .force_q(force_q), .div_q(div_q)
  );

  always_comb begin
    if (cfg_q[CFG_OVR])       src_req = SRC_DIV;
    else if (cfg_q[CFG_SLOW]) src_req = SRC_SLOW;
    else                      src_req = SRC_FAST;
    duty_sel   = cfg_q[CFG_PROG] ? set_q[DW-1 -: CW] : lut_duty[DW-1 -: CW];
    lut_index  = (!cfg_q[CFG_PROG] && cfg_q[CFG_FORCE]) ? force_q : meas_temp;
    limit_temp = meas_temp;
  end

  fan_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .DW(DW)) u_tick (
    .clk(clk), .rst_n(rst_n), .src(src_q), .div_val(div_q), .tick(base_tick)
  );

  fan_pwm_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .duty_in(duty_sel),
    .invert(cfg_q[CFG_INV]), .src_req(src_req), .src_q(src_q),
    .duty_q(duty_q), .cnt_q(cnt_q), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [7:0] cfg_q,
  input logic [7:0] set_q,
  input logic [7:0] lut_duty,
  input logic [5:0] duty_q,
  input logic [5:0] cnt_q,
  input logic       base_tick,
  input logic       pwm_out
);
  logic boundary;
  assign boundary = base_tick && (cnt_q == 6'h3F);

  a_r1_reset_values: assert property (@(posedge clk)
    $rose(rst_n) |-> (cfg_q == 8'h20 && set_q == 8'h00 && !pwm_out));

  a_r2_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> !reg_rdata[7]);

  a_r3_set_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && cfg_q[5]) |=> set_q == $past(reg_wdata));

  a_r4_set_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && !cfg_q[5]) |=> $stable(set_q));

  a_r4_lut_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !cfg_q[5]) |=> duty_q == 6'($past(lut_duty) >> 2));

  a_r7_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == 6'd0) |=> pwm_out == $past(cfg_q[4]));

  a_r8_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == 6'h3F) |=> pwm_out != $past(cfg_q[4]));

  a_r10_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(duty_q));
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_q(cfg_q),
  .set_q(set_q), .lut_duty(lut_duty), .duty_q(duty_q), .cnt_q(cnt_q),
  .base_tick(base_tick), .pwm_out(pwm_out)
);

// File: tb/fan_pwm_ctrl_tb_top.sv
module fan_pwm_ctrl_tb_top;
  localparam int FAST = 4;
  localparam int SLOW = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] meas_temp = 8'h00;
  logic [7:0] lut_duty = 8'h00;
  logic [7:0] lut_index, limit_temp;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  int prev_t = FAST;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fan_pwm_ctrl #(.FAST_DIV(FAST), .SLOW_DIV(SLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .meas_temp(meas_temp),
    .lut_duty(lut_duty), .lut_index(lut_index), .limit_temp(limit_temp),
    .pwm_out(pwm_out)
  );

  function automatic int exp_high(logic [7:0] d, logic inv, int t);
    int h;
    h = (d[7:2] == 6'h3F) ? 64 : int'(d[7:2]);
    h = h * t;
    return inv ? 64 * t - h : h;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #5 d = reg_rdata;
  endtask

  task automatic duty_check(string req, logic [7:0] d, logic inv, int t);
    int hi;
    hi = 0;
    repeat (128 * (t + prev_t)) @(negedge clk);
    prev_t = t;
    repeat (64 * t) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    check(req, hi, exp_high(d, inv, t));
  endtask

  bit mon_en = 1'b0;
  bit run_ok = 1'b0;
  int run_len = 0;
  logic mon_prev = 1'b0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (pwm_out != mon_prev) begin
        if (run_ok) check("R10 run length mod tick", run_len % FAST, 0);
        run_ok = 1'b1;
        run_len = 1;
      end else begin
        run_len++;
      end
    end else begin
      run_ok = 1'b0;
      run_len = 0;
    end
    mon_prev = pwm_out;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d, m, f, c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    meas_temp = 8'h2A;

    // R1 reset state
    rd(2'd0, r); check("R1 cfg reset", r, 8'h20);
    rd(2'd1, r); check("R1 setting reset", r, 8'h00);
    check("R1 pwm low", pwm_out, 0);

    // R2 register map and bit 7
    wr(2'd2, 8'h5C); rd(2'd2, r); check("R2 forced temp readback", r, 8'h5C);
    wr(2'd3, 8'h07); rd(2'd3, r); check("R2 divisor readback", r, 8'h07);
    wr(2'd0, 8'hA3); rd(2'd0, r); check("R2 bit7 zero, tach bits kept", r, 8'h23);

    // R2 tach bits no effect / R3 setting drives duty, lut ignored
    lut_duty = 8'hFF;
    wr(2'd1, 8'h80);
    duty_check("R2 R3 setting 0x80 with tach bits", 8'h80, 0, FAST);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h00); duty_check("R7 duty zero", 8'h00, 0, FAST);
    wr(2'd1, 8'hFC); duty_check("R7 duty full", 8'hFC, 0, FAST);
    wr(2'd1, 8'h07); duty_check("R7 duty below one step", 8'h07, 0, FAST);

    // R8 inversion
    wr(2'd0, 8'h30); wr(2'd1, 8'h00);
    duty_check("R8 inverted zero", 8'h00, 1, FAST);
    wr(2'd1, 8'hA0); duty_check("R8 inverted 0xA0", 8'hA0, 1, FAST);

    // R9 tick sources
    wr(2'd0, 8'h28); wr(2'd1, 8'h40);
    duty_check("R9 slow tick", 8'h40, 0, SLOW);
    wr(2'd3, 8'h03); wr(2'd0, 8'h2C);
    duty_check("R9 divisor 3 ignores slow bit", 8'h40, 0, FAST * 3);
    wr(2'd3, 8'h00);
    duty_check("R9 divisor 0 acts as 1", 8'h40, 0, FAST);
    wr(2'd3, 8'h02); wr(2'd0, 8'h24);
    duty_check("R9 divisor 2", 8'h40, 0, FAST * 2);
    wr(2'd0, 8'h20);
    duty_check("R9 back to fast", 8'h40, 0, FAST);

    // R4 table mode
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h11); rd(2'd1, r); check("R4 setting write blocked", r, 8'h40);
    lut_duty = 8'h60;
    duty_check("R4 duty follows lut", 8'h60, 0, FAST);

    // R5 R6 index selection
    wr(2'd2, 8'h77);
    for (int i = 0; i < 8; i++) begin
      m = 8'($urandom); f = 8'($urandom);
      c = {1'b0, 1'($urandom), 1'($urandom), 5'h00};
      wr(2'd2, f); wr(2'd0, c);
      meas_temp = m;
      #5;
      check("R5 index", lut_index, (!c[5] && c[6]) ? f : m);
      check("R6 limit", limit_temp, m);
    end

    // random manual duty/polarity
    for (int i = 0; i < 6; i++) begin
      d = 8'($urandom);
      c = 8'h20 | (8'($urandom) & 8'h10);
      lut_duty = 8'($urandom);
      wr(2'd0, c); wr(2'd1, d);
      duty_check("R3 R7 random setting", d, c[4], FAST);
    end
    // random table duty
    wr(2'd0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      lut_duty = 8'($urandom);
      wr(2'd1, 8'($urandom));
      duty_check("R4 random lut", lut_duty, 0, FAST);
    end

    // R10 writes at random offsets, runs stay whole ticks
    wr(2'd0, 8'h20);
    repeat (600) @(negedge clk);
    mon_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      repeat (1 + ($urandom % 90)) @(negedge clk);
      wr(2'd1, 8'($urandom));
    end
    repeat (600) @(negedge clk);
    mon_en = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule